// File: doc/BRIEF.md
# Power Mode and Wake Controller

This block turns two asynchronous control pins, a suspend request and a power-down request, into one of four operating modes. From the mode it drives the enables for the analog and digital power domains and for the gate on the master and word clock outputs. It also arms an external tone detector and latches a wake flag when that detector reports tone energy for long enough.

After an asynchronous active-low reset, a start-up counter holds the clock gate closed for a parameterised number of master-clock cycles. The default is about 2 ms at 35.328 MHz. A short count can be set for simulation. Both mode pins and the comparator input pass through two-flop synchronisers before any logic uses them.

The wake flag is set only while the part sits in Suspend with the detector enabled. Once set, it holds through every other mode and clears only when the part returns to Active. A programmable run length of consecutive synchronised comparator samples filters out short bursts of noise.

Top module: `pwr_wake_ctrl`

States of the start-up sequencer: BOOT_COUNT (clock gate held closed, counter advancing) goes to BOOT_RUN once the count reaches BOOT_CYCLES. BOOT_RUN is left only by reset.

States of the wake machine:
- WK_OFF (detector disarmed) goes to WK_LISTEN when the detector becomes armed.
- WK_LISTEN goes back to WK_OFF on disarm. On a hit it goes to WK_QUALIFY, or straight to WK_WOKE when the run length is 0 or 1.
- WK_QUALIFY goes to WK_LISTEN when the hit drops, to WK_OFF on disarm, and to WK_WOKE once the run is complete.
- WK_WOKE goes to WK_OFF on entry to Active.

## Requirements
- R1: mode_o reports the synchronised pins as {suspend, pwdn}: 2'b00 Active, 2'b01 Enumerating, 2'b10 Suspend, 2'b11 Standby. A pin change reaches mode_o and the enables within two clock edges.
- R2: In Active, ana_pwr_en_o=1, dig_pwr_en_o=1 and tone_arm_o=0, and clk_gate_o=1 once start-up is done.
- R3: In Enumerating, ana_pwr_en_o=0, dig_pwr_en_o=1 and clk_gate_o=1 after start-up.
- R4: In Suspend, ana_pwr_en_o=0, dig_pwr_en_o=0 and clk_gate_o=0.
- R5: In Standby, ana_pwr_en_o=0, dig_pwr_en_o=0, clk_gate_o=0 and tone_arm_o=0.
- R6: After reset is released, clk_gate_o stays 0 for BOOT_CYCLES-1 rising edges and becomes 1 at edge BOOT_CYCLES, given the suspend pin is low.
- R7: tone_arm_o is 1 only in Suspend with tone_en_i=1. tone_sel_o repeats tone_sel_i: 0 selects tone 40, 1 selects tone 72.
- R8: wake_o latches only after tone_hit_i has been seen high for qual_len_i consecutive synchronised samples while armed. A shorter run does not latch it. A qual_len_i of 0 behaves as 1.
- R9: Once set, wake_o stays 1 while the hit is gone and through Enumerating, Standby and Suspend. It clears only on entry to Active.
- R10: tone_hit_i has no effect on wake_o while unarmed: in Active, in Enumerating, or in Suspend with tone_en_i=0.
- R11: An asynchronous reset clears wake_o and clk_gate_o at once and restarts the start-up count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| suspend_i | input | 1 | Suspend request pin (asynchronous) |
| pwdn_i | input | 1 | Power-down request pin (asynchronous) |
| tone_en_i | input | 1 | Register bit: detector enabled during sleep |
| tone_sel_i | input | 1 | Register bit: tone select (0 tone 40, 1 tone 72) |
| tone_hit_i | input | 1 | Comparator: tone energy above threshold (asynchronous) |
| qual_len_i | input | QUAL_W | Consecutive samples needed to latch a wake |
| mode_o | output | 2 | Current mode {suspend, pwdn} |
| clk_gate_o | output | 1 | Enable for the master and word clock outputs |
| ana_pwr_en_o | output | 1 | Analog domain power enable |
| dig_pwr_en_o | output | 1 | Digital domain power enable |
| tone_arm_o | output | 1 | Tone detector armed |
| tone_sel_o | output | 1 | Tone select passed to the detector |
| wake_o | output | 1 | Latched wake request |

## Verification
The bench counts clock edges across the start-up window. A sequencer off by one edge would open the clock gate one cycle early or late. It drives hit runs one sample shorter than the run length and exactly equal to it. A qualifier that counts from the wrong base would latch on the short run or miss the exact one. It walks a latched wake through Enumerating, Standby and Suspend with the comparator quiet. A design that clears on any non-Suspend mode, or on the hit dropping, would lose the flag there. It also applies long hits while unarmed, and resets in the middle of a cycle to check the asynchronous clear of the flag and of the clock gate.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;

    // Encoding is {suspend, pwdn}; the bit order is relied on by decode logic.
    typedef enum logic [1:0] {
        MODE_ACTIVE  = 2'b00,
        MODE_ENUM    = 2'b01,
        MODE_SUSPEND = 2'b10,
        MODE_STANDBY = 2'b11
    } op_mode_e;

    typedef enum logic {
        BOOT_COUNT = 1'b0,
        BOOT_RUN   = 1'b1
    } boot_state_e;

    typedef enum logic [1:0] {
        WK_OFF     = 2'b00,
        WK_LISTEN  = 2'b01,
        WK_QUALIFY = 2'b10,
        WK_WOKE    = 2'b11
    } wake_state_e;

endpackage

// File: rtl/pw_sync2.sv
module pw_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
        end
    end

    assign q = stab_q;
endmodule

// File: rtl/pw_boot_seq.sv
module pw_boot_seq
    import pwr_wake_pkg::*;
#(
    parameter int BOOT_CYCLES = 70656
) (
    input  logic clk,
    input  logic rst_n,
    output logic boot_done
);
    localparam int CNT_W = $clog2(BOOT_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BOOT_CYCLES - 1);

    boot_state_e       state_q;
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BOOT_COUNT;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                BOOT_COUNT: begin
                    if (cnt_q == LAST) begin
                        state_q <= BOOT_RUN;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                BOOT_RUN: state_q <= BOOT_RUN;
                default:  state_q <= BOOT_COUNT;
            endcase
        end
    end

    always_comb begin
        boot_done = (state_q == BOOT_RUN);
    end

    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(BOOT_CYCLES));

    // R6
    boot_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done |=> boot_done);
endmodule

// File: rtl/pw_wake_fsm.sv
module pw_wake_fsm
    import pwr_wake_pkg::*;
#(
    parameter int QUAL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_mode_e          mode,
    input  logic              tone_en,
    input  logic              hit_s,
    input  logic [QUAL_W-1:0] qual_len,
    output logic              armed,
    output logic              wake
);
    localparam int RUN_W = QUAL_W + 1;

    wake_state_e      state_q, state_d;
    logic [RUN_W-1:0] run_q, run_d;
    logic [RUN_W-1:0] need;

    assign armed = (mode == MODE_SUSPEND) && tone_en;
    assign need  = (qual_len == '0) ? RUN_W'(1) : RUN_W'(qual_len);

    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        unique case (state_q)
            WK_OFF: begin
                run_d = '0;
                if (armed) state_d = WK_LISTEN;
            end
            WK_LISTEN: begin
                run_d = '0;
                if (!armed) begin
                    state_d = WK_OFF;
                end else if (hit_s) begin
                    run_d   = RUN_W'(1);
                    state_d = (need <= RUN_W'(1)) ? WK_WOKE : WK_QUALIFY;
                end
            end
            WK_QUALIFY: begin
                if (!armed) begin
                    state_d = WK_OFF;
                    run_d   = '0;
                end else if (!hit_s) begin
                    state_d = WK_LISTEN;
                    run_d   = '0;
                end else if (run_q + 1'b1 >= need) begin
                    state_d = WK_WOKE;
                end else begin
                    run_d = run_q + 1'b1;
                end
            end
            WK_WOKE: begin
                run_d = '0;
                if (mode == MODE_ACTIVE) state_d = WK_OFF;
            end
            default: state_d = WK_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WK_OFF;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
        end
    end

    always_comb begin
        wake = (state_q == WK_WOKE);
    end

    // R8
    wake_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake) |-> ($past(mode) == MODE_SUSPEND) && $past(tone_en) && $past(hit_s));

    // R9
    wake_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wake) |-> ($past(mode) == MODE_ACTIVE));
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
    import pwr_wake_pkg::*;
#(
    parameter int BOOT_CYCLES = 70656,
    parameter int QUAL_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              suspend_i,
    input  logic              pwdn_i,
    input  logic              tone_en_i,
    input  logic              tone_sel_i,
    input  logic              tone_hit_i,
    input  logic [QUAL_W-1:0] qual_len_i,
    output logic [1:0]        mode_o,
    output logic              clk_gate_o,
    output logic              ana_pwr_en_o,
    output logic              dig_pwr_en_o,
    output logic              tone_arm_o,
    output logic              tone_sel_o,
    output logic              wake_o
);
    logic [2:0] raw_pins;
    logic [2:0] sync_pins;
    op_mode_e   mode_s;
    logic       hit_s;
    logic       boot_done;
    logic       armed;
    logic       wake;

    assign raw_pins = {tone_hit_i, suspend_i, pwdn_i};

    pw_sync2 #(.W(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_pins),
        .q     (sync_pins)
    );

    assign mode_s = op_mode_e'(sync_pins[1:0]);
    assign hit_s  = sync_pins[2];

    pw_boot_seq #(.BOOT_CYCLES(BOOT_CYCLES)) u_boot (
        .clk       (clk),
        .rst_n     (rst_n),
        .boot_done (boot_done)
    );

    pw_wake_fsm #(.QUAL_W(QUAL_W)) u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode_s),
        .tone_en  (tone_en_i),
        .hit_s    (hit_s),
        .qual_len (qual_len_i),
        .armed    (armed),
        .wake     (wake)
    );

    always_comb begin
        ana_pwr_en_o = 1'b0;
        dig_pwr_en_o = 1'b0;
        clk_gate_o   = 1'b0;
        unique case (mode_s)
            MODE_ACTIVE: begin
                ana_pwr_en_o = 1'b1;
                dig_pwr_en_o = 1'b1;
                clk_gate_o   = boot_done;
            end
            MODE_ENUM: begin
                dig_pwr_en_o = 1'b1;
                clk_gate_o   = boot_done;
            end
            MODE_SUSPEND: begin
            end
            MODE_STANDBY: begin
            end
            default: begin
            end
        endcase
    end

    assign mode_o     = mode_s;
    assign tone_arm_o = armed;
    assign tone_sel_o = tone_sel_i;
    assign wake_o     = wake;

    // R7
    arm_no_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tone_arm_o |-> !clk_gate_o && !ana_pwr_en_o);

    // R6
    gate_after_boot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_gate_o |-> boot_done);
endmodule

// File: tb/tb_pwr_wake_ctrl.sv
module tb_pwr_wake_ctrl;
    localparam int BOOT = 20;
    localparam int QW   = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          suspend_i = 1'b0;
    logic          pwdn_i = 1'b0;
    logic          tone_en_i = 1'b0;
    logic          tone_sel_i = 1'b0;
    logic          tone_hit_i = 1'b0;
    logic [QW-1:0] qual_len_i = 4'd3;
    logic [1:0]    mode_o;
    logic          clk_gate_o, ana_pwr_en_o, dig_pwr_en_o;
    logic          tone_arm_o, tone_sel_o, wake_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwr_wake_ctrl #(.BOOT_CYCLES(BOOT), .QUAL_W(QW)) dut (
        .clk(clk), .rst_n(rst_n), .suspend_i(suspend_i), .pwdn_i(pwdn_i),
        .tone_en_i(tone_en_i), .tone_sel_i(tone_sel_i), .tone_hit_i(tone_hit_i),
        .qual_len_i(qual_len_i), .mode_o(mode_o), .clk_gate_o(clk_gate_o),
        .ana_pwr_en_o(ana_pwr_en_o), .dig_pwr_en_o(dig_pwr_en_o),
        .tone_arm_o(tone_arm_o), .tone_sel_o(tone_sel_o), .wake_o(wake_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_mode(input logic s, input logic p);
        suspend_i = s;
        pwdn_i    = p;
        cyc(3);
    endtask

    task automatic hit_run(input int n);
        tone_hit_i = 1'b1;
        cyc(n);
        tone_hit_i = 1'b0;
        cyc(4);
    endtask

    task automatic t_boot;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R6", "gate right after reset", clk_gate_o, 0);
        chk("R11", "wake after reset", wake_o, 0);
        chk("R1", "mode after reset", mode_o, 0);
        cyc(BOOT - 1);
        chk("R6", "gate at edge BOOT-1", clk_gate_o, 0);
        cyc(1);
        chk("R6", "gate at edge BOOT", clk_gate_o, 1);
    endtask

    task automatic t_modes;
        tone_en_i = 1'b1;
        set_mode(1'b0, 1'b0);
        chk("R1", "mode active", mode_o, 0);
        chk("R2", "active ana", ana_pwr_en_o, 1);
        chk("R2", "active dig", dig_pwr_en_o, 1);
        chk("R2", "active gate", clk_gate_o, 1);
        chk("R2", "active arm", tone_arm_o, 0);
        set_mode(1'b0, 1'b1);
        chk("R1", "mode enum", mode_o, 1);
        chk("R3", "enum ana", ana_pwr_en_o, 0);
        chk("R3", "enum dig", dig_pwr_en_o, 1);
        chk("R3", "enum gate", clk_gate_o, 1);
        set_mode(1'b1, 1'b0);
        chk("R1", "mode suspend", mode_o, 2);
        chk("R4", "suspend ana", ana_pwr_en_o, 0);
        chk("R4", "suspend dig", dig_pwr_en_o, 0);
        chk("R4", "suspend gate", clk_gate_o, 0);
        chk("R7", "suspend arm", tone_arm_o, 1);
        set_mode(1'b1, 1'b1);
        chk("R1", "mode standby", mode_o, 3);
        chk("R5", "standby ana", ana_pwr_en_o, 0);
        chk("R5", "standby dig", dig_pwr_en_o, 0);
        chk("R5", "standby gate", clk_gate_o, 0);
        chk("R5", "standby arm", tone_arm_o, 0);
        suspend_i = 1'b0;
        pwdn_i    = 1'b0;
        cyc(1);
        chk("R1", "one edge after change", mode_o, 3);
        cyc(1);
        chk("R1", "two edges after change", mode_o, 0);
    endtask

    task automatic t_arm_sel;
        set_mode(1'b1, 1'b0);
        tone_en_i = 1'b0;
        cyc(1);
        chk("R7", "suspend disabled arm", tone_arm_o, 0);
        tone_en_i  = 1'b1;
        tone_sel_i = 1'b1;
        cyc(1);
        chk("R7", "suspend enabled arm", tone_arm_o, 1);
        chk("R7", "select tone 72", tone_sel_o, 1);
        tone_sel_i = 1'b0;
        cyc(1);
        chk("R7", "select tone 40", tone_sel_o, 0);
        set_mode(1'b0, 1'b0);
    endtask

    task automatic t_unarmed;
        set_mode(1'b0, 1'b0);
        qual_len_i = 4'd1;
        hit_run(8);
        chk("R10", "hit in active", wake_o, 0);
        set_mode(1'b0, 1'b1);
        hit_run(8);
        chk("R10", "hit in enum", wake_o, 0);
        tone_en_i = 1'b0;
        set_mode(1'b1, 1'b0);
        hit_run(8);
        chk("R10", "hit in suspend disabled", wake_o, 0);
        tone_en_i = 1'b1;
        set_mode(1'b0, 1'b0);
    endtask

    task automatic t_qualify;
        qual_len_i = 4'd3;
        set_mode(1'b1, 1'b0);
        cyc(2);
        hit_run(2);
        chk("R8", "run of 2 with length 3", wake_o, 0);
        hit_run(3);
        chk("R8", "run of 3 with length 3", wake_o, 1);
        set_mode(1'b0, 1'b0);
        chk("R9", "clear on active", wake_o, 0);
        qual_len_i = 4'd0;
        set_mode(1'b1, 1'b0);
        cyc(2);
        hit_run(1);
        chk("R8", "length 0 acts as 1", wake_o, 1);
        set_mode(1'b0, 1'b0);
    endtask

    task automatic t_hold;
        qual_len_i = 4'd2;
        set_mode(1'b1, 1'b0);
        cyc(2);
        hit_run(2);
        chk("R8", "run of 2 with length 2", wake_o, 1);
        cyc(5);
        chk("R9", "held after hit drops", wake_o, 1);
        set_mode(1'b0, 1'b1);
        chk("R9", "held in enum", wake_o, 1);
        set_mode(1'b1, 1'b1);
        chk("R9", "held in standby", wake_o, 1);
        set_mode(1'b1, 1'b0);
        chk("R9", "held in suspend", wake_o, 1);
        suspend_i = 1'b0;
        pwdn_i    = 1'b0;
        cyc(2);
        chk("R9", "still set as active is sampled", wake_o, 1);
        cyc(1);
        chk("R9", "clears after active", wake_o, 0);
    endtask

    task automatic t_async_reset;
        qual_len_i = 4'd1;
        set_mode(1'b1, 1'b0);
        cyc(2);
        hit_run(1);
        chk("R8", "wake before reset", wake_o, 1);
        set_mode(1'b0, 1'b0);
        qual_len_i = 4'd1;
        set_mode(1'b1, 1'b0);
        cyc(2);
        hit_run(1);
        suspend_i = 1'b0;
        #3 rst_n = 1'b0;
        #1;
        chk("R11", "wake cleared asynchronously", wake_o, 0);
        chk("R11", "gate cleared asynchronously", clk_gate_o, 0);
        cyc(2);
        rst_n = 1'b1;
        cyc(BOOT - 1);
        chk("R11", "gate still closed after restart", clk_gate_o, 0);
        cyc(1);
        chk("R11", "gate open after restart", clk_gate_o, 1);
    endtask

    initial begin
        cyc(3);
        t_boot();
        t_modes();
        t_arm_sel();
        t_unarmed();
        t_qualify();
        t_hold();
        t_async_reset();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule